// File: doc/BRIEF.md
# Ring Bid Collector and Selector Node

Each node on a unidirectional ring carries one instance of this block. A node that wants to hand a job to another node launches a token. The token carries the job number, the launching node's index, and one bid slot per ring position. Every other node that the token passes writes its own slot before passing the token on. If the node can take the job, it writes its present queue depth and sets the slot's valid bit. If it cannot, it clears the slot.

When the token comes back to its launcher with the pending job number, the node does not forward it. It scans the slots in downstream order and picks the valid bidder with the smallest queue depth. It then issues a commit naming that node, together with a one-cycle strobe that tells the successor neighbour to refresh its backup copy. If nobody bid, the node raises a no-taker strobe instead. After a commit, the launching side stays suspended until the delegated job is reported finished.

Top module: `ring_bid_node`

## Requirements
- R1: After reset, `tok_out_valid`, `commit_valid`, `no_taker`, `notify` and `suspended` are all low.
- R2: A launch happens when the node is idle, `req_valid` is high and no token is arriving. One cycle later `tok_out_valid` is high, with `tok_out_job` = `req_job`, `tok_out_origin` = `node_id` and every bid slot zero, and `suspended` is high.
- R3: A token whose origin differs from `node_id` is forwarded one cycle later, with job, origin and all other slots unchanged. Slot k sits at bits [k*(QW+1)+QW : k*(QW+1)], with the valid bit at the top. The node's own slot becomes {1, `queue_len`} when `can_accept` is high, and all zero otherwise.
- R4: A token arriving in the same cycle as a launch request is forwarded first, and the launch takes place in the following cycle.
- R5: A token that returns while the node awaits it, carrying the pending job number, is not forwarded. One cycle later `commit_valid` pulses for exactly one cycle, with `commit_job` equal to the pending job.
- R6: `commit_node` is the valid bidder with the smallest queue depth. On a tie, the bidder with the smallest downstream distance (k - node_id) mod NODES wins. The launcher's own slot is never chosen.
- R7: If the returned token holds no valid bid, `no_taker` pulses for one cycle instead of a commit, and `suspended` falls in the same cycle.
- R8: `notify` pulses in the cycle of every commit.
- R9: After a commit, `suspended` stays high until `job_done` is sampled high. One cycle later it is low and a new launch is accepted.
- R10: A token carrying the node's own index is dropped without effect when the node is not awaiting a return, or when the job number does not match. `tok_out_valid`, `commit_valid` and `no_taker` stay low.
- R11: While suspended, `req_valid` launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | IW | Ring position of this node |
| can_accept | input | 1 | Node is willing to take foreign jobs |
| queue_len | input | QW | Current local queue depth |
| req_valid | input | 1 | Request to delegate a job |
| req_job | input | JW | Job number to delegate |
| job_done | input | 1 | Delegated job reported finished |
| tok_in_valid | input | 1 | Incoming token present |
| tok_in_job | input | JW | Incoming token job number |
| tok_in_origin | input | IW | Incoming token launcher index |
| tok_in_bids | input | NODES*(QW+1) | Incoming bid slots |
| tok_out_valid | output | 1 | Outgoing token present |
| tok_out_job | output | JW | Outgoing token job number |
| tok_out_origin | output | IW | Outgoing token launcher index |
| tok_out_bids | output | NODES*(QW+1) | Outgoing bid slots |
| commit_valid | output | 1 | Commit strobe |
| commit_node | output | IW | Selected node |
| commit_job | output | JW | Committed job number |
| no_taker | output | 1 | Returned token held no bid |
| notify | output | 1 | Successor backup update strobe |
| suspended | output | 1 | Launching job is waiting |

## Verification
The hardest situation to reach is a returned token whose slot pattern exposes the tie rule and the exclusion of the launcher's own slot. The bench therefore plays the rest of the ring itself: it launches, then feeds back a hand-built return token for every combination of valid bit and depth in the three foreign slots. It does this for each launcher position, so that wrap-around distance ordering is covered. The launcher's own slot is always filled with an attractive zero-depth bid that must be ignored.

// File: rtl/ring_bid_pkg.sv
package ring_bid_pkg;
  typedef enum logic [1:0] {
    RB_IDLE      = 2'd0,
    RB_WAIT_RET  = 2'd1,
    RB_WAIT_DONE = 2'd2
  } rb_state_e;
endpackage

// File: rtl/rb_stamp.sv
// Writes this node's slot into a passing token.
module rb_stamp #(
  parameter int NODES = 8,
  parameter int QW    = 8,
  localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int FW   = QW + 1
) (
  input  logic [IW-1:0]       node_id,
  input  logic                can_accept,
  input  logic [QW-1:0]       queue_len,
  input  logic [NODES*FW-1:0] bids_in,
  output logic [NODES*FW-1:0] bids_out
);
  always_comb begin
    bids_out = bids_in;
    for (int k = 0; k < NODES; k++) begin
      if (int'(node_id) == k)
        bids_out[k*FW +: FW] = can_accept ? {1'b1, queue_len} : '0;
    end
  end
endmodule

// File: rtl/rb_select.sv
// Least-loaded bidder, scanned in downstream order from the launcher.
module rb_select #(
  parameter int NODES = 8,
  parameter int QW    = 8,
  localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int FW   = QW + 1
) (
  input  logic [IW-1:0]       origin,
  input  logic [NODES*FW-1:0] bids,
  output logic                any_bid,
  output logic [IW-1:0]       best_node
);
  logic [QW-1:0] best_q;
  logic [FW-1:0] slot;
  int            idx;

  always_comb begin
    any_bid   = 1'b0;
    best_node = '0;
    best_q    = '0;
    slot      = '0;
    idx       = 0;
    for (int d = 1; d < NODES; d++) begin
      idx  = (int'(origin) + d) % NODES;
      slot = bids[idx*FW +: FW];
      if (slot[FW-1] && (!any_bid || slot[QW-1:0] < best_q)) begin
        any_bid   = 1'b1;
        best_q    = slot[QW-1:0];
        best_node = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/rb_ctrl.sv
// Launch / await-return / await-completion sequencing.
module rb_ctrl
  import ring_bid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic tok_in_valid,
  input  logic own_match,
  input  logic any_bid,
  input  logic job_done,
  output logic launch,
  output logic ret_hit,
  output logic suspended
);
  rb_state_e state_q, state_d;

  assign launch    = (state_q == RB_IDLE) && req_valid && !tok_in_valid;
  assign ret_hit   = (state_q == RB_WAIT_RET) && own_match;
  assign suspended = (state_q != RB_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RB_IDLE:      if (launch)   state_d = RB_WAIT_RET;
      RB_WAIT_RET:  if (ret_hit)  state_d = any_bid ? RB_WAIT_DONE : RB_IDLE;
      RB_WAIT_DONE: if (job_done) state_d = RB_IDLE;
      default:                    state_d = RB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RB_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ring_bid_node.sv
module ring_bid_node #(
  parameter int NODES = 8,
  parameter int QW    = 8,
  parameter int JW    = 8,
  localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int FW   = QW + 1,
  localparam int BW   = NODES * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] node_id,
  input  logic          can_accept,
  input  logic [QW-1:0] queue_len,
  input  logic          req_valid,
  input  logic [JW-1:0] req_job,
  input  logic          job_done,
  input  logic          tok_in_valid,
  input  logic [JW-1:0] tok_in_job,
  input  logic [IW-1:0] tok_in_origin,
  input  logic [BW-1:0] tok_in_bids,
  output logic          tok_out_valid,
  output logic [JW-1:0] tok_out_job,
  output logic [IW-1:0] tok_out_origin,
  output logic [BW-1:0] tok_out_bids,
  output logic          commit_valid,
  output logic [IW-1:0] commit_node,
  output logic [JW-1:0] commit_job,
  output logic          no_taker,
  output logic          notify,
  output logic          suspended
);
  logic          own_tok, own_match, fwd, launch, ret_hit, any_bid;
  logic [IW-1:0] best_node;
  logic [BW-1:0] stamped;
  logic [JW-1:0] pend_job_q;

  assign own_tok   = tok_in_valid && (tok_in_origin == node_id);
  assign own_match = own_tok && (tok_in_job == pend_job_q);
  assign fwd       = tok_in_valid && !own_tok;

  rb_stamp #(.NODES(NODES), .QW(QW)) u_stamp (
    .node_id(node_id), .can_accept(can_accept), .queue_len(queue_len),
    .bids_in(tok_in_bids), .bids_out(stamped));

  rb_select #(.NODES(NODES), .QW(QW)) u_select (
    .origin(node_id), .bids(tok_in_bids),
    .any_bid(any_bid), .best_node(best_node));

  rb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .tok_in_valid(tok_in_valid), .own_match(own_match), .any_bid(any_bid),
    .job_done(job_done), .launch(launch), .ret_hit(ret_hit),
    .suspended(suspended));

  // Outgoing token stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_out_valid  <= 1'b0;
      tok_out_job    <= '0;
      tok_out_origin <= '0;
      tok_out_bids   <= '0;
    end else begin
      tok_out_valid <= fwd || launch;
      if (fwd) begin
        tok_out_job    <= tok_in_job;
        tok_out_origin <= tok_in_origin;
        tok_out_bids   <= stamped;
      end else if (launch) begin
        tok_out_job    <= req_job;
        tok_out_origin <= node_id;
        tok_out_bids   <= '0;
      end
    end
  end

  // Pending job number
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_job_q <= '0;
    else if (launch) pend_job_q <= req_job;
  end

  // Decision outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
      no_taker     <= 1'b0;
      notify       <= 1'b0;
      commit_node  <= '0;
      commit_job   <= '0;
    end else begin
      commit_valid <= ret_hit && any_bid;
      notify       <= ret_hit && any_bid;
      no_taker     <= ret_hit && !any_bid;
      if (ret_hit && any_bid) begin
        commit_node <= best_node;
        commit_job  <= pend_job_q;
      end
    end
  end
endmodule

// File: rtl/ring_bid_sva.sv
module ring_bid_sva #(
  parameter int NODES = 8,
  parameter int QW    = 8,
  parameter int JW    = 8,
  localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW   = NODES * (QW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] node_id,
  input logic          job_done,
  input logic          tok_out_valid,
  input logic [IW-1:0] tok_out_origin,
  input logic [BW-1:0] tok_out_bids,
  input logic          commit_valid,
  input logic [IW-1:0] commit_node,
  input logic          no_taker,
  input logic          notify,
  input logic          suspended
);
  AST_LAUNCH_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> tok_out_valid && tok_out_origin == node_id && tok_out_bids == '0); // R2
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid); // R5
  AST_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_node != node_id); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && no_taker)); // R7
  AST_NOTAKER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    no_taker |-> !suspended); // R7
  AST_NOTIFY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> notify); // R8
  AST_HOLD_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> suspended); // R9
endmodule

bind ring_bid_node ring_bid_sva #(.NODES(NODES), .QW(QW), .JW(JW)) u_sva (
  .clk(clk), .rst_n(rst_n), .node_id(node_id), .job_done(job_done),
  .tok_out_valid(tok_out_valid), .tok_out_origin(tok_out_origin),
  .tok_out_bids(tok_out_bids), .commit_valid(commit_valid),
  .commit_node(commit_node), .no_taker(no_taker), .notify(notify),
  .suspended(suspended));

// File: tb/tb_ring_bid_node.sv
module tb_ring_bid_node;
  localparam int NODES = 4;
  localparam int QW    = 3;
  localparam int JW    = 4;
  localparam int IW    = 2;
  localparam int FW    = QW + 1;
  localparam int BW    = NODES * FW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] node_id;
  logic          can_accept;
  logic [QW-1:0] queue_len;
  logic          req_valid;
  logic [JW-1:0] req_job;
  logic          job_done;
  logic          tok_in_valid;
  logic [JW-1:0] tok_in_job;
  logic [IW-1:0] tok_in_origin;
  logic [BW-1:0] tok_in_bids;
  logic          tok_out_valid;
  logic [JW-1:0] tok_out_job;
  logic [IW-1:0] tok_out_origin;
  logic [BW-1:0] tok_out_bids;
  logic          commit_valid;
  logic [IW-1:0] commit_node;
  logic [JW-1:0] commit_job;
  logic          no_taker;
  logic          notify;
  logic          suspended;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ring_bid_node #(.NODES(NODES), .QW(QW), .JW(JW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    req_valid = 0; job_done = 0; tok_in_valid = 0;
    tok_in_job = '0; tok_in_origin = '0; tok_in_bids = '0;
  endtask

  initial begin
    wait (cyc >= 190000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; node_id = 0; can_accept = 0; queue_len = 0;
    req_job = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1
    chk(!tok_out_valid && !commit_valid && !no_taker && !notify && !suspended,
        "R1 reset", {tok_out_valid, commit_valid, no_taker, notify, suspended}, 0);
    rst_n = 1;

    // R3 forwarding sweep
    for (int id = 0; id < NODES; id++) begin
      for (int ca = 0; ca < 2; ca++) begin
        for (int q = 0; q < (1 << QW); q++) begin
          logic [BW-1:0] exp_b;
          @(negedge clk);
          node_id = IW'(id); can_accept = ca[0]; queue_len = QW'(q);
          tok_in_valid = 1; tok_in_job = JW'(q + id);
          tok_in_origin = IW'((id + 1) % NODES);
          tok_in_bids = BW'(16'hA5C3 ^ (q * 16'h1111));
          exp_b = tok_in_bids;
          exp_b[id*FW +: FW] = ca[0] ? {1'b1, QW'(q)} : '0;
          edge_sample();
          chk(tok_out_valid && tok_out_job == JW'(q + id) &&
              tok_out_origin == IW'((id + 1) % NODES) && tok_out_bids == exp_b,
              "R3 forward", tok_out_bids, exp_b);
        end
      end
    end
    @(negedge clk); idle_inputs();
    edge_sample();

    // R10 stale own token while idle
    @(negedge clk);
    node_id = 2; tok_in_valid = 1; tok_in_origin = 2; tok_in_job = 5; tok_in_bids = '1;
    edge_sample();
    chk(!tok_out_valid && !commit_valid && !no_taker, "R10 stale idle",
        {tok_out_valid, commit_valid, no_taker}, 0);

    // R4 forward wins over launch
    @(negedge clk);
    tok_in_origin = 1; tok_in_job = 9; tok_in_bids = '0; can_accept = 0;
    req_valid = 1; req_job = 7;
    edge_sample();
    chk(tok_out_valid && tok_out_origin == 1 && tok_out_job == 9 && !suspended,
        "R4 forward first", {tok_out_origin, tok_out_job}, {2'd1, 4'd9});
    @(negedge clk); tok_in_valid = 0;
    edge_sample();
    chk(tok_out_valid && tok_out_origin == 2 && tok_out_job == 7 && suspended,
        "R4 deferred launch", {tok_out_origin, tok_out_job}, {2'd2, 4'd7});

    // R11 no relaunch while suspended
    @(negedge clk); req_job = 3;
    edge_sample();
    chk(!tok_out_valid && suspended, "R11 ignored request", tok_out_valid, 0);
    @(negedge clk); req_valid = 0;

    // R10 mismatched job while awaiting
    tok_in_valid = 1; tok_in_origin = 2; tok_in_job = 6; tok_in_bids = {4'b1001, 12'h0};
    edge_sample();
    chk(!tok_out_valid && !commit_valid && !no_taker && suspended,
        "R10 job mismatch", {tok_out_valid, commit_valid, no_taker, suspended}, 1);

    // R5/R9 matching return, then hold until done
    @(negedge clk); tok_in_job = 7;
    edge_sample();
    chk(commit_valid && commit_job == 7 && commit_node == 3 && !tok_out_valid,
        "R5 commit", {commit_node, commit_job}, {2'd3, 4'd7});
    @(negedge clk); tok_in_valid = 0;
    edge_sample();
    chk(!commit_valid && suspended, "R9 held", {commit_valid, suspended}, 1);
    edge_sample();
    chk(suspended, "R9 still held", suspended, 1);
    @(negedge clk); job_done = 1;
    edge_sample();
    chk(!suspended, "R9 released", suspended, 0);
    @(negedge clk); idle_inputs();

    // R2 R5 R6 R7 R8 R9 exhaustive return sweep
    for (int id = 0; id < NODES; id++) begin
      for (int c = 0; c < (1 << (3 * FW)); c++) begin
        logic [BW-1:0] bids;
        logic [JW-1:0] jb;
        int best, bq, k;
        jb = JW'(c ^ id);
        bids = '0;
        bids[id*FW +: FW] = {1'b1, QW'(0)};
        best = -1; bq = 0;
        for (int d = 1; d < NODES; d++) begin
          logic [FW-1:0] f;
          k = (id + d) % NODES;
          f = FW'(c >> ((d - 1) * FW));
          bids[k*FW +: FW] = f;
          if (f[FW-1] && (best < 0 || int'(f[QW-1:0]) < bq)) begin
            best = k; bq = int'(f[QW-1:0]);
          end
        end
        @(negedge clk);
        node_id = IW'(id); req_valid = 1; req_job = jb;
        edge_sample();
        chk(tok_out_valid && tok_out_job == jb && tok_out_origin == IW'(id) &&
            tok_out_bids == '0 && suspended, "R2 launch", tok_out_bids, 0);
        @(negedge clk);
        req_valid = 0; tok_in_valid = 1; tok_in_job = jb;
        tok_in_origin = IW'(id); tok_in_bids = bids;
        edge_sample();
        if (best >= 0) begin
          chk(commit_valid && !no_taker && notify && commit_node == IW'(best) &&
              commit_job == jb && suspended && !tok_out_valid,
              "R6 select", commit_node, best);
        end else begin
          chk(no_taker && !commit_valid && !notify && !suspended && !tok_out_valid,
              "R7 no taker", {no_taker, commit_valid, suspended}, 3'b100);
        end
        @(negedge clk);
        tok_in_valid = 0; job_done = (best >= 0);
        edge_sample();
        chk(!commit_valid && !no_taker && !notify && !suspended,
            "R8 strobe single", {commit_valid, no_taker, notify, suspended}, 0);
        @(negedge clk); job_done = 0;
      end
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule